// File: doc/BRIEF.md
# Adaptive-Threshold Spiking Encoder

This block turns a stream of signed samples into a train of single-cycle spike strobes, in the manner of a one-bit error-feedback encoder. Each accepted sample is multiplied by a weight and accumulated into a leaky input trace. A feedback kernel is subtracted from that trace. The kernel is charged by every emitted spike and drains away exponentially. A spike is issued when the remaining error is larger than a firing threshold. The threshold is not fixed. Every spike scales it up by a programmable factor. Between spikes it drifts back toward a resting level. A burst of strong input therefore becomes progressively harder to follow with more spikes, and the event rate stays bounded.

All arithmetic is integer. Every decay is a right shift, so the datapath needs no divider. The only multipliers are the input weighting and the threshold scaling. The adaptation factor is an unsigned fixed-point number with six fraction bits. The threshold is clamped between the resting value and a programmable ceiling. The encoder advances one step for each cycle in which `in_valid` is high and is frozen otherwise. The current effective threshold is always visible on `thr_out`.

Top module: `spike_adapt_encoder`

## Requirements
- R1: While `rst_n` is low and in the cycle after its release, `spike` is 0 and `thr_out` equals `cfg_thr_rest`. The trace, the kernel and the stored threshold are all cleared.
- R2: In a cycle without `in_valid`, no spike is emitted in the following cycle. The trace, the kernel and the threshold keep their values, so `thr_out` does not change while the configuration is held.
- R3: For a valid sample, the trace first becomes trace − (trace >>> `cfg_kern_shift`) + sample × `cfg_weight`. The weight is unsigned and the result saturates to the signed ACC_W range. The error is this new trace minus the decayed kernel. `spike` is high in the next cycle exactly when the error is strictly greater than the current effective threshold.
- R4: On each valid step the kernel decays to kernel − (kernel >> `cfg_kern_shift`). When that step fires, the effective threshold in force is added to the kernel, and the sum saturates at 2^(ACC_W−1)−1. A charged kernel suppresses a spike that the bare trace alone would cause.
- R5: On a firing step the stored threshold becomes floor(threshold × `cfg_adapt` / 64). `cfg_adapt` is unsigned Q2.6, so 64 means 1.0. The result rounds toward zero.
- R6: On a valid step that does not fire, the threshold becomes thr − ((thr − rest) >> `cfg_thr_shift`). The effective threshold never falls below `cfg_thr_rest`.
- R7: The effective threshold never exceeds `cfg_thr_max`. A growth step that would pass it lands exactly on `cfg_thr_max`.
- R8: Starting from reset, a stream made only of negative samples never produces a spike.
- R9: With a constant positive sample, the spike count stabilises. After settling, two successive 256-step windows differ by at most 2 spikes, and neither window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Advances the encoder by one step with `in_sample` |
| in_sample | input | DATA_W | Signed input sample |
| cfg_weight | input | WGT_W | Unsigned input weight |
| cfg_thr_rest | input | THR_W | Resting (minimum) threshold |
| cfg_thr_max | input | THR_W | Threshold ceiling |
| cfg_adapt | input | ADAPT_W | Threshold growth factor, unsigned Q2.6 |
| cfg_kern_shift | input | SH_W | Decay shift shared by the input trace and the kernel |
| cfg_thr_shift | input | SH_W | Relaxation shift of the threshold toward rest |
| spike | output | 1 | One-cycle spike strobe, registered |
| thr_out | output | THR_W | Current effective threshold |

## Verification
The hardest state to reach from the ports is a charged feedback kernel that alone decides the outcome. This is a step where the trace by itself clears the threshold but the residue of an earlier spike holds it back. The stimulus reaches it with a strong first sample that fires at unity adaptation. A fast decay shift then lets the trace and the kernel fall by half, and a moderate second sample lands the error between zero and the threshold. The stalled relaxation of the threshold just above rest and the clamp at the ceiling are also reached by construction. Each is driven by a chosen shift or an extreme growth factor.

// File: rtl/spk_enc_pkg.sv
// Shared constants of the adaptive-threshold spiking encoder.
// Assumes the growth factor carries six fraction bits.
package spk_enc_pkg;
    localparam int ADAPT_FRAC = 6;
    localparam int ADAPT_ONE  = 1 << ADAPT_FRAC;
endpackage

// File: rtl/spk_input_trace.sv
// Leaky integrator of weighted samples. It computes the post-step trace
// combinationally and stores it on a valid step.
// Assumes ACC_W >= DATA_W + WGT_W + 1 so the product fits before saturation.
module spk_input_trace #(
    parameter int DATA_W = 12,
    parameter int WGT_W  = 8,
    parameter int ACC_W  = 24,
    parameter int SH_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  logic signed [DATA_W-1:0] sample,
    input  logic [WGT_W-1:0]         weight,
    input  logic [SH_W-1:0]          shift,
    output logic signed [ACC_W-1:0]  trace_next
);
    localparam int PROD_W = DATA_W + WGT_W + 1;
    localparam int EXT_W  = ACC_W + 2;

    logic signed [ACC_W-1:0]  trace_q;
    logic signed [ACC_W-1:0]  trace_dec;
    logic signed [PROD_W-1:0] samp_x, wgt_x, prod;
    logic signed [EXT_W-1:0]  sum;

    // Weighted sample: the sign-extended sample times the zero-extended weight.
    always_comb begin
        samp_x = PROD_W'(sample);
        wgt_x  = $signed(PROD_W'({1'b0, weight}));
        prod   = samp_x * wgt_x;
    end

    // Leak by arithmetic shift, add the new sample, saturate to ACC_W.
    always_comb begin
        trace_dec = trace_q >>> shift;
        sum = $signed({{2{trace_q[ACC_W-1]}}, trace_q})
            - $signed({{2{trace_dec[ACC_W-1]}}, trace_dec})
            + $signed({{(EXT_W-PROD_W){prod[PROD_W-1]}}, prod});
        if (sum > $signed({3'b000, {(ACC_W-1){1'b1}}}))
            trace_next = $signed({1'b0, {(ACC_W-1){1'b1}}});
        else if (sum < $signed({3'b111, {(ACC_W-1){1'b0}}}))
            trace_next = $signed({1'b1, {(ACC_W-1){1'b0}}});
        else
            trace_next = sum[ACC_W-1:0];
    end

    // Trace register: cleared by reset, updated only on a valid step.
    always_ff @(posedge clk) begin
        if (!rst_n)    trace_q <= '0;
        else if (step) trace_q <= trace_next;
    end
endmodule

// File: rtl/spk_kernel.sv
// Refractory feedback kernel. It decays by a right shift on every valid step
// and is charged with the effective threshold when that step fires.
// Assumes THR_W < ACC_W. The kernel is kept non-negative, ACC_W-1 bits.
module spk_kernel #(
    parameter int ACC_W = 24,
    parameter int THR_W = 16,
    parameter int SH_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               fire,
    input  logic [THR_W-1:0]   thr_eff,
    input  logic [SH_W-1:0]    shift,
    output logic [ACC_W-2:0]   kern_dec
);
    logic [ACC_W-2:0] kern_q;
    logic [ACC_W-1:0] charged;

    // Decayed kernel, plus the saturating charge used on a firing step.
    always_comb begin
        kern_dec = kern_q - (kern_q >> shift);
        charged  = {1'b0, kern_dec} + {{(ACC_W-THR_W){1'b0}}, thr_eff};
    end

    // Kernel register: decay each step, add the threshold on a spike.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kern_q <= '0;
        else if (step) begin
            if (!fire)                kern_q <= kern_dec;
            else if (charged[ACC_W-1]) kern_q <= '1;
            else                      kern_q <= charged[ACC_W-2:0];
        end
    end

    // A step without a spike never lets the kernel grow.
    assert_kern_decays_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step && !fire) |-> kern_q <= $past(kern_q));
endmodule

// File: rtl/spk_threshold.sv
// Adaptive firing threshold. A spike scales it by a Q2.6 factor, rounding
// toward zero and capping at the ceiling. A quiet valid step relaxes it
// toward rest by a shift. The effective value is clamped into [rest, max].
// Assumes rest <= max for a meaningful range.
module spk_threshold
    import spk_enc_pkg::*;
#(
    parameter int THR_W   = 16,
    parameter int ADAPT_W = 8,
    parameter int SH_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               fire,
    input  logic [THR_W-1:0]   rest,
    input  logic [THR_W-1:0]   ceil_v,
    input  logic [ADAPT_W-1:0] adapt,
    input  logic [SH_W-1:0]    shift,
    output logic [THR_W-1:0]   thr_eff
);
    localparam int PW = THR_W + ADAPT_W;

    logic [THR_W-1:0] thr_q, capped, grown, relaxed;
    logic [PW-1:0]    prod, scaled;

    // Effective threshold: cap at the ceiling first, then floor at rest.
    always_comb begin
        capped  = (thr_q > ceil_v) ? ceil_v : thr_q;
        thr_eff = (capped < rest) ? rest : capped;
    end

    // Candidate next values for a firing step and for a quiet step.
    always_comb begin
        prod    = PW'(thr_eff) * PW'(adapt);
        scaled  = prod >> ADAPT_FRAC;
        grown   = (scaled > PW'(ceil_v)) ? ceil_v : scaled[THR_W-1:0];
        relaxed = thr_eff - ((thr_eff - rest) >> shift);
    end

    // Threshold register: updated only on a valid step.
    always_ff @(posedge clk) begin
        if (!rst_n)    thr_q <= '0;
        else if (step) thr_q <= fire ? grown : relaxed;
    end

    // Without a step and with the limits held, the threshold is frozen.
    assert_thr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!step) && $stable(rest) && $stable(ceil_v) |-> $stable(thr_eff));

    // A quiet step only ever lowers the threshold toward rest.
    assert_thr_relaxes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(step && !fire) && $stable(rest) && $stable(ceil_v)
        |-> thr_eff <= $past(thr_eff));
endmodule

// File: rtl/spike_adapt_encoder.sv
// Adaptive-threshold spiking encoder top. It joins the input trace, the
// feedback kernel and the adaptive threshold, compares the error with the
// threshold and registers the spike strobe.
// Assumes THR_W < ACC_W and ACC_W >= DATA_W + WGT_W + 1.
module spike_adapt_encoder
    import spk_enc_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int WGT_W   = 8,
    parameter int ACC_W   = 24,
    parameter int THR_W   = 16,
    parameter int ADAPT_W = 8,
    parameter int SH_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_sample,
    input  logic [WGT_W-1:0]         cfg_weight,
    input  logic [THR_W-1:0]         cfg_thr_rest,
    input  logic [THR_W-1:0]         cfg_thr_max,
    input  logic [ADAPT_W-1:0]       cfg_adapt,
    input  logic [SH_W-1:0]          cfg_kern_shift,
    input  logic [SH_W-1:0]          cfg_thr_shift,
    output logic                     spike,
    output logic [THR_W-1:0]         thr_out
);
    logic signed [ACC_W-1:0] trace_next;
    logic [ACC_W-2:0]        kern_dec;
    logic [THR_W-1:0]        thr_eff;
    logic signed [ACC_W:0]   err;
    logic                    fire;

    spk_input_trace #(.DATA_W(DATA_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .SH_W(SH_W)) i_trace (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .sample(in_sample),
        .weight(cfg_weight), .shift(cfg_kern_shift), .trace_next(trace_next));

    spk_kernel #(.ACC_W(ACC_W), .THR_W(THR_W), .SH_W(SH_W)) i_kernel (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .fire(fire),
        .thr_eff(thr_eff), .shift(cfg_kern_shift), .kern_dec(kern_dec));

    spk_threshold #(.THR_W(THR_W), .ADAPT_W(ADAPT_W), .SH_W(SH_W)) i_thr (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .fire(fire),
        .rest(cfg_thr_rest), .ceil_v(cfg_thr_max), .adapt(cfg_adapt),
        .shift(cfg_thr_shift), .thr_eff(thr_eff));

    // Error against the feedback, compared strictly with the threshold.
    always_comb begin
        err  = $signed({trace_next[ACC_W-1], trace_next}) - $signed({2'b00, kern_dec});
        fire = in_valid && (err > $signed({{(ACC_W+1-THR_W){1'b0}}, thr_eff}));
    end

    // Registered spike strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) spike <= 1'b0;
        else        spike <= fire;
    end

    assign thr_out = thr_eff;

    // No step, no spike.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !spike);

    // A non-positive trace can never fire.
    assert_nonpos_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (trace_next <= 0) |=> !spike);

    // With a growth factor of at least one, a spike never lowers the threshold.
    assert_spike_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spike && (cfg_adapt >= ADAPT_W'(ADAPT_ONE)) && $stable(cfg_adapt)
        && $stable(cfg_thr_rest) && $stable(cfg_thr_max)
        |-> thr_out >= $past(thr_out));
endmodule

// File: tb/test_spike_adapt_encoder.sv
// Directed bench: one task per scenario, each checking its own results
// against a step model written from the requirements.
module test_spike_adapt_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 12, WGT_W = 8, ACC_W = 24, THR_W = 16, ADAPT_W = 8, SH_W = 5;
    localparam longint SMAX = (64'sd1 <<< (ACC_W-1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (ACC_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_sample = '0;
    logic [WGT_W-1:0]   cfg_weight = '0;
    logic [THR_W-1:0]   cfg_thr_rest = '0, cfg_thr_max = '0;
    logic [ADAPT_W-1:0] cfg_adapt = '0;
    logic [SH_W-1:0]    cfg_kern_shift = '0, cfg_thr_shift = '0;
    logic               spike;
    logic [THR_W-1:0]   thr_out;

    int n_checks = 0;
    int n_err = 0;
    longint m_sig, m_kern, m_thr;
    logic last_spike;

    spike_adapt_encoder #(.DATA_W(DATA_W), .WGT_W(WGT_W), .ACC_W(ACC_W), .THR_W(THR_W),
                          .ADAPT_W(ADAPT_W), .SH_W(SH_W)) i_spike_adapt_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cfg_weight(cfg_weight), .cfg_thr_rest(cfg_thr_rest), .cfg_thr_max(cfg_thr_max),
        .cfg_adapt(cfg_adapt), .cfg_kern_shift(cfg_kern_shift), .cfg_thr_shift(cfg_thr_shift),
        .spike(spike), .thr_out(thr_out));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint eff_thr(longint t);
        longint r;
        r = (t > longint'(cfg_thr_max)) ? longint'(cfg_thr_max) : t;
        if (r < longint'(cfg_thr_rest)) r = longint'(cfg_thr_rest);
        return r;
    endfunction

    // One encoder step as the requirements define it.
    task automatic model_step(input bit v, input longint x, output bit fired);
        longint s, kd, te, sc;
        fired = 1'b0;
        if (v) begin
            s = m_sig - (m_sig >>> cfg_kern_shift) + x * longint'(cfg_weight);
            if (s > SMAX) s = SMAX;
            if (s < SMIN) s = SMIN;
            kd = m_kern - (m_kern >>> cfg_kern_shift);
            te = eff_thr(m_thr);
            fired = (s - kd) > te;
            if (fired) begin
                m_kern = (kd + te > SMAX) ? SMAX : kd + te;
                sc = (te * longint'(cfg_adapt)) / 64;
                m_thr = (sc > longint'(cfg_thr_max)) ? longint'(cfg_thr_max) : sc;
            end else begin
                m_kern = kd;
                m_thr = te - ((te - longint'(cfg_thr_rest)) >>> cfg_thr_shift);
            end
            m_sig = s;
        end
    endtask

    task automatic run_step(input bit v, input longint x, input string req);
        bit exp_sp;
        in_valid  = v;
        in_sample = DATA_W'(x);
        @(posedge clk);
        @(negedge clk);
        model_step(v, x, exp_sp);
        last_spike = spike;
        check({req, " spike"}, longint'(spike), longint'(exp_sp));
        check({req, " threshold"}, longint'(thr_out), eff_thr(m_thr));
        in_valid = 1'b0;
    endtask

    task automatic set_cfg(input int rest, input int mx, input int ad, input int ks,
                           input int ts, input int w);
        cfg_thr_rest = THR_W'(rest); cfg_thr_max = THR_W'(mx); cfg_adapt = ADAPT_W'(ad);
        cfg_kern_shift = SH_W'(ks); cfg_thr_shift = SH_W'(ts); cfg_weight = WGT_W'(w);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_sig = 0; m_kern = 0; m_thr = 0;
    endtask

    // R1: clean state out of reset.
    task automatic test_reset();
        set_cfg(100, 1000, 96, 3, 2, 1);
        do_reset();
        check("R1 spike after reset", longint'(spike), 0);
        check("R1 thr_out after reset", longint'(thr_out), 100);
    endtask

    // R3, R5, R2, R6: single pulse, idle hold, then relaxation toward rest.
    task automatic test_pulse_idle_relax();
        run_step(1'b1, 200, "R3 pulse");
        check("R3 pulse fires", longint'(last_spike), 1);
        check("R5 growth 100*1.5", longint'(thr_out), 150);
        for (int i = 0; i < 8; i++) run_step(1'b0, 0, "R2 idle");
        check("R2 thr held while idle", longint'(thr_out), 150);
        for (int i = 0; i < 40; i++) run_step(1'b1, 0, "R6 relax");
        check("R6 relax stalls above rest", longint'(thr_out), 103);
    endtask

    // R4: a charged kernel holds back a spike the bare trace would cause.
    task automatic test_kernel();
        set_cfg(100, 1000, 64, 1, 2, 1);
        do_reset();
        run_step(1'b1, 150, "R4 charge");
        check("R4 first sample fires", longint'(last_spike), 1);
        check("R4 unity growth keeps thr", longint'(thr_out), 100);
        run_step(1'b1, 40, "R4 blocked");
        check("R4 kernel suppresses spike", longint'(last_spike), 0);
        for (int i = 0; i < 30; i++) run_step(1'b1, 30, "R4 stream");
    endtask

    // R5: growth rounds toward zero.
    task automatic test_rounding();
        set_cfg(100, 1000, 65, 3, 2, 1);
        do_reset();
        run_step(1'b1, 200, "R5 round a");
        check("R5 floor(100*65/64)", longint'(thr_out), 101);
        set_cfg(100, 1000, 127, 3, 2, 1);
        do_reset();
        run_step(1'b1, 200, "R5 round b");
        check("R5 floor(100*127/64)", longint'(thr_out), 198);
    endtask

    // R7: threshold pinned at the ceiling.
    task automatic test_ceiling();
        set_cfg(100, 500, 255, 3, 4, 255);
        do_reset();
        for (int i = 0; i < 6; i++) run_step(1'b1, 2047, "R7 saturate");
        check("R7 thr at ceiling", longint'(thr_out), 500);
    endtask

    // R8: negative samples never fire.
    task automatic test_negative();
        int cnt = 0;
        set_cfg(100, 1000, 96, 3, 2, 3);
        do_reset();
        for (int i = 0; i < 150; i++) begin
            run_step(1'b1, -300, "R8 negative");
            cnt += int'(last_spike);
        end
        for (int i = 0; i < 50; i++) begin
            run_step(1'b1, -1, "R8 small negative");
            cnt += int'(last_spike);
        end
        check("R8 spike count", cnt, 0);
    endtask

    // R9: steady rate under constant drive.
    task automatic test_rate();
        int c1 = 0, c2 = 0;
        set_cfg(100, 4000, 80, 4, 3, 2);
        do_reset();
        for (int i = 0; i < 512; i++) run_step(1'b1, 60, "R9 settle");
        for (int i = 0; i < 256; i++) begin
            run_step(1'b1, 60, "R9 window1");
            c1 += int'(last_spike);
        end
        for (int i = 0; i < 256; i++) begin
            run_step(1'b1, 60, "R9 window2");
            c2 += int'(last_spike);
        end
        check("R9 window nonempty", longint'(c1 > 0), 1);
        check("R9 rate stable", longint'((c1 > c2 ? c1 - c2 : c2 - c1) <= 2), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_pulse_idle_relax();
        test_kernel();
        test_rounding();
        test_ceiling();
        test_negative();
        test_rate();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule